// File: doc/BRIEF.md
# Aligned Contiguous Slot Allocator

This block keeps a map of interrupt-number slots and hands them out on request. Each slot carries two flags: a level-type flag and a message-type flag. A slot with neither flag set is free. An allocation marks each slot it takes with exactly one of the two flags, chosen by the requester. Three operations are offered: a block allocation of one or more consecutive slots, a single allocation of one named slot, and a release of a range of slots.

A block allocation scans candidate start positions in rising order. It can start at any index, or it can be limited to starts that are whole multiples of the block size. The scan tests one slot per clock. It gives up as soon as the block would run past the end of the map. A successful result reports the start index plus a fixed base number. A failed result reports all ones, which is −1 in two's complement.

The block has a plain request/response handshake. It raises `busy` from the cycle it accepts a request until the cycle it answers. The answer is a one-cycle `resp_valid` pulse that carries exactly one outcome flag. The flag maps are visible at the ports, so a neighbour can see which slots are taken and what type each one has.

Top module: `slot_alloc`

## Requirements
- R1: After reset all slots are free (`slot_lvl` and `slot_msg` are all zero), `busy` is low and `resp_valid` is low.
- R2: A successful allocation sets, on every slot it covers, `slot_lvl` when `req_lvl`=1 and `slot_msg` when `req_lvl`=0. No slot ever has both flags set.
- R3: A block allocation (`req_op`=0) tries candidate starts 0, A, 2A, … in that order. A equals the count when `req_align`=1 and equals 1 otherwise. The first candidate whose slots are all free wins, and `resp_num` = start + BASE with `resp_ok`=1.
- R4: A block allocation fails (`resp_fail`=1, `resp_num` all ones) when a candidate start plus the count exceeds NUM_SLOTS. A failure leaves the flags unchanged.
- R5: An error response (`resp_err`=1, `resp_num` all ones, flags unchanged) is given for any of these cases: a block allocation with count 0; an aligned block allocation whose count is not 1, 2, 4, 8, 16 or 32; a release with count 0 or a range past the end of the map; the reserved code `req_op`=3.
- R6: A single allocation (`req_op`=1) of slot `req_slot` succeeds with `resp_num` = slot + BASE only if that slot is free. Otherwise it fails without any search. Either way it answers on the first clock after acceptance.
- R7: A release (`req_op`=2) of `req_count` slots starting at `req_slot` clears both flags on every slot in the range. It answers `resp_ok`, with `resp_warn`=1 when any slot in the range was already free.
- R8: `busy` is high from the clock after acceptance until the answer. `resp_valid` is a single-cycle pulse with exactly one of `resp_ok`, `resp_fail` and `resp_err`. A request presented while `busy` is high is ignored.
- R9: The scan tests one slot per clock. On an empty map, an unaligned block allocation of n slots answers n clocks after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 2 | 0 block allocate, 1 single allocate, 2 release, 3 reserved |
| req_count | input | $clog2(MAX_COUNT+1) | Number of slots to allocate or release |
| req_align | input | 1 | Block allocation restricted to starts that are multiples of the count |
| req_lvl | input | 1 | Type of the new slots: 1 level, 0 message |
| req_slot | input | $clog2(NUM_SLOTS) | Slot for a single allocation, or first slot of a release |
| busy | output | 1 | Request in progress |
| resp_valid | output | 1 | One-cycle answer strobe |
| resp_ok | output | 1 | Operation succeeded |
| resp_fail | output | 1 | No room, or the named slot is taken |
| resp_err | output | 1 | Illegal request, no state changed |
| resp_warn | output | 1 | Release covered an already-free slot |
| resp_num | output | NUM_W | Start slot plus BASE, or all ones |
| slot_lvl | output | NUM_SLOTS | Level-type flag of each slot |
| slot_msg | output | NUM_SLOTS | Message-type flag of each slot |

## Verification
The assertions check properties that must hold on every clock. They check that no slot carries both type flags. They check the shape of the answer: a single pulse, exactly one outcome, and only after a busy period. They check that failures and errors leave both flag maps untouched and carry an all-ones number. They check that the maps stay still while the block is idle. Only the bench scenarios can show the rest: which start the scan picks under a given occupancy and alignment, the one-slot-per-clock latency, the warning on a release of free slots, and that a request presented during a scan is dropped. The bench shows these by sweeping counts and alignment over several occupancy patterns and comparing each answer with an arithmetic first-fit model.

// File: rtl/slot_alloc.sv
`timescale 1ns/1ps
module slot_alloc #(
  parameter int NUM_SLOTS = 16,
  parameter int MAX_COUNT = 32,
  parameter int MAX_ALIGN = 32,
  parameter int BASE      = 4096,
  parameter int NUM_W     = 16,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int CW = $clog2(MAX_COUNT + 1),
  localparam int AW = $clog2(NUM_SLOTS + MAX_COUNT) + 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic [CW-1:0]        req_count,
  input  logic                 req_align,
  input  logic                 req_lvl,
  input  logic [SW-1:0]        req_slot,
  output logic                 busy,
  output logic                 resp_valid,
  output logic                 resp_ok,
  output logic                 resp_fail,
  output logic                 resp_err,
  output logic                 resp_warn,
  output logic [NUM_W-1:0]     resp_num,
  output logic [NUM_SLOTS-1:0] slot_lvl,
  output logic [NUM_SLOTS-1:0] slot_msg
);
  localparam logic [1:0] OP_BLOCK = 2'd0;
  localparam logic [1:0] OP_HINT  = 2'd1;
  localparam logic [1:0] OP_FREE  = 2'd2;

  logic [1:0]           op_q;
  logic [CW-1:0]        cnt_q, idx_q;
  logic                 align_q, lvl_q;
  logic [SW-1:0]        slot_q;
  logic [AW-1:0]        cand_q;
  logic [NUM_SLOTS-1:0] used, blk_mask, rng_mask, hint_mask;
  logic [NUM_SLOTS-1:0] lvl_fill, msg_fill;

  logic [AW-1:0] cnt_w, slot_w, cur, stride;
  logic          too_far, cur_free, pow2, blk_bad, rng_bad, hint_bad, last, warn;

  assign used     = slot_lvl | slot_msg;
  assign cnt_w    = AW'(cnt_q);
  assign slot_w   = AW'(slot_q);
  assign cur      = cand_q + AW'(idx_q);
  assign stride   = align_q ? cnt_w : AW'(1);
  assign too_far  = (cand_q + cnt_w) > AW'(NUM_SLOTS);
  assign cur_free = (cur < AW'(NUM_SLOTS)) && !used[cur[SW-1:0]];
  assign pow2     = (cnt_q != '0) && ((cnt_q & (cnt_q - CW'(1))) == '0)
                    && (cnt_w <= AW'(MAX_ALIGN));
  assign blk_bad  = (cnt_q == '0) || (align_q && !pow2);
  assign rng_bad  = (cnt_q == '0) || ((slot_w + cnt_w) > AW'(NUM_SLOTS));
  assign hint_bad = slot_w >= AW'(NUM_SLOTS);
  assign last     = idx_q == (cnt_q - CW'(1));
  assign hint_mask = NUM_SLOTS'(1) << slot_q;
  assign lvl_fill = {NUM_SLOTS{lvl_q}};
  assign msg_fill = ~lvl_fill;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      blk_mask[i] = (AW'(i) >= cand_q) && (AW'(i) < cand_q + cnt_w);
      rng_mask[i] = (AW'(i) >= slot_w) && (AW'(i) < slot_w + cnt_w);
    end
  end

  assign warn = |(rng_mask & ~used);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; op_q <= '0; cnt_q <= '0; idx_q <= '0; align_q <= 1'b0;
      lvl_q <= 1'b0; slot_q <= '0; cand_q <= '0;
      resp_valid <= 1'b0; resp_ok <= 1'b0; resp_fail <= 1'b0;
      resp_err <= 1'b0; resp_warn <= 1'b0; resp_num <= '0;
      slot_lvl <= '0; slot_msg <= '0;
    end else begin
      resp_valid <= 1'b0; resp_ok <= 1'b0; resp_fail <= 1'b0;
      resp_err <= 1'b0; resp_warn <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy <= 1'b1; op_q <= req_op; cnt_q <= req_count;
          align_q <= req_align; lvl_q <= req_lvl; slot_q <= req_slot;
          cand_q <= '0; idx_q <= '0;
        end
      end else begin
        case (op_q)
          OP_BLOCK: begin
            if (blk_bad) begin
              busy <= 1'b0; resp_valid <= 1'b1; resp_err <= 1'b1; resp_num <= '1;
            end else if (idx_q == '0 && too_far) begin
              busy <= 1'b0; resp_valid <= 1'b1; resp_fail <= 1'b1; resp_num <= '1;
            end else if (!cur_free) begin
              cand_q <= cand_q + stride;
              idx_q  <= '0;
            end else if (last) begin
              slot_lvl <= slot_lvl | (blk_mask & lvl_fill);
              slot_msg <= slot_msg | (blk_mask & msg_fill);
              busy <= 1'b0; resp_valid <= 1'b1; resp_ok <= 1'b1;
              resp_num <= NUM_W'(cand_q) + NUM_W'(BASE);
            end else begin
              idx_q <= idx_q + CW'(1);
            end
          end
          OP_HINT: begin
            busy <= 1'b0; resp_valid <= 1'b1;
            if (hint_bad) begin
              resp_err <= 1'b1; resp_num <= '1;
            end else if (used[slot_q]) begin
              resp_fail <= 1'b1; resp_num <= '1;
            end else begin
              slot_lvl <= slot_lvl | (hint_mask & lvl_fill);
              slot_msg <= slot_msg | (hint_mask & msg_fill);
              resp_ok  <= 1'b1;
              resp_num <= NUM_W'(slot_q) + NUM_W'(BASE);
            end
          end
          OP_FREE: begin
            busy <= 1'b0; resp_valid <= 1'b1;
            if (rng_bad) begin
              resp_err <= 1'b1; resp_num <= '1;
            end else begin
              slot_lvl  <= slot_lvl & ~rng_mask;
              slot_msg  <= slot_msg & ~rng_mask;
              resp_ok   <= 1'b1;
              resp_warn <= warn;
              resp_num  <= NUM_W'(slot_q) + NUM_W'(BASE);
            end
          end
          default: begin
            busy <= 1'b0; resp_valid <= 1'b1; resp_err <= 1'b1; resp_num <= '1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/slot_alloc_chk.sv
`timescale 1ns/1ps
module slot_alloc_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_W     = 16
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 resp_valid,
  input logic                 resp_ok,
  input logic                 resp_fail,
  input logic                 resp_err,
  input logic [NUM_W-1:0]     resp_num,
  input logic [NUM_SLOTS-1:0] slot_lvl,
  input logic [NUM_SLOTS-1:0] slot_msg
);
  a_r2_one_type: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_lvl & slot_msg) == '0);

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({resp_ok, resp_fail, resp_err}) == 1);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r8_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(busy) && !busy);

  a_r4_fail_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fail) |-> ($stable(slot_lvl) && $stable(slot_msg)
                                   && resp_num == '1));

  a_r5_err_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> ($stable(slot_lvl) && $stable(slot_msg)
                                  && resp_num == '1));

  a_r8_idle_map_still: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(slot_lvl) && $stable(slot_msg)));
endmodule

bind slot_alloc slot_alloc_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_W(NUM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .resp_valid(resp_valid),
  .resp_ok(resp_ok), .resp_fail(resp_fail), .resp_err(resp_err),
  .resp_num(resp_num), .slot_lvl(slot_lvl), .slot_msg(slot_msg)
);

// File: tb/slot_alloc_tb.sv
`timescale 1ns/1ps
module slot_alloc_tb_top;
  localparam int N = 16, BASEV = 4096, CW = 6, SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_align = 1'b0, req_lvl = 1'b0;
  logic [1:0] req_op = '0;
  logic [CW-1:0] req_count = '0;
  logic [SW-1:0] req_slot = '0;
  logic busy, resp_valid, resp_ok, resp_fail, resp_err, resp_warn;
  logic [15:0] resp_num;
  logic [N-1:0] slot_lvl, slot_msg;

  always #2.5 clk = ~clk;

  slot_alloc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_count(req_count), .req_align(req_align), .req_lvl(req_lvl),
    .req_slot(req_slot), .busy(busy), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_fail(resp_fail), .resp_err(resp_err),
    .resp_warn(resp_warn), .resp_num(resp_num),
    .slot_lvl(slot_lvl), .slot_msg(slot_msg)
  );

  int checks = 0, fails = 0;
  logic [N-1:0] mlvl = '0, mmsg = '0;
  int r_code, r_num, r_warn, lat;
  logic busy_seen;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_map(input string tag);
    chk({tag, " lvl map"}, int'(slot_lvl), int'(mlvl));
    chk({tag, " msg map"}, int'(slot_msg), int'(mmsg));
  endtask

  task automatic issue(input logic [1:0] op, input int cnt, input bit al,
                       input bit lv, input int slot);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_count = CW'(cnt);
    req_align = al; req_lvl = lv; req_slot = SW'(slot);
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = busy;
    lat = 0;
    while (!resp_valid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    if (!resp_valid) begin
      checks++; fails++;
      $display("FAIL R8 no answer: actual %0d expected %0d", lat, 0);
      r_code = 3;
    end else begin
      r_code = resp_ok ? 0 : resp_fail ? 1 : resp_err ? 2 : 3;
    end
    r_num  = int'(resp_num);
    r_warn = int'(resp_warn);
  endtask

  function automatic void model_block(input int cnt, input bit al,
                                      output int code, output int st);
    logic [N-1:0] u;
    int stride;
    bit legal_al;
    u = mlvl | mmsg;
    legal_al = (cnt == 1 || cnt == 2 || cnt == 4 || cnt == 8 || cnt == 16 || cnt == 32);
    code = 1; st = -1;
    if (cnt == 0 || (al && !legal_al)) begin
      code = 2;
      return;
    end
    stride = al ? cnt : 1;
    for (int c = 0; c + cnt <= N; c += stride) begin
      bit ok;
      ok = 1'b1;
      for (int k = 0; k < cnt; k++) if (u[c + k]) ok = 1'b0;
      if (ok) begin
        code = 0; st = c;
        return;
      end
    end
  endfunction

  task automatic model_set(input int st, input int cnt, input bit lv);
    for (int k = st; k < st + cnt; k++) begin
      if (lv) mlvl[k] = 1'b1; else mmsg[k] = 1'b1;
    end
  endtask

  task automatic model_clr(input int st, input int cnt);
    for (int k = st; k < st + cnt; k++) begin
      mlvl[k] = 1'b0; mmsg[k] = 1'b0;
    end
  endtask

  task automatic sweep(input logic [N-1:0] pat);
    int exp_warn, code, st;
    exp_warn = ((mlvl | mmsg) != '1) ? 1 : 0;
    issue(2'd2, N, 1'b0, 1'b0, 0);
    chk("R7 clear all ok", r_code, 0);
    chk("R7 clear all warn", r_warn, exp_warn);
    model_clr(0, N);
    chk_map("R7 clear all");
    for (int i = 0; i < N; i++) begin
      if (pat[i]) begin
        issue(2'd1, 1, 1'b0, i[0], i);
        chk("R6 hint ok", r_code, 0);
        chk("R6 hint num", r_num, BASEV + i);
        chk("R6 hint latency", lat, 1);
        model_set(i, 1, i[0]);
      end
    end
    chk_map("R2 after hints");
    for (int cnt = 0; cnt <= 17; cnt++) begin
      for (int al = 0; al < 2; al++) begin
        model_block(cnt, al[0], code, st);
        issue(2'd0, cnt, al[0], cnt[0], 0);
        if (code == 0) begin
          chk("R3 block outcome", r_code, 0);
          chk("R3 block start", r_num, BASEV + st);
          model_set(st, cnt, cnt[0]);
          chk_map("R2 block map");
          issue(2'd2, cnt, 1'b0, 1'b0, st);
          chk("R7 release ok", r_code, 0);
          chk("R7 release no warn", r_warn, 0);
          model_clr(st, cnt);
          chk_map("R7 release map");
        end else if (code == 1) begin
          chk("R4 block outcome", r_code, 1);
          chk("R4 fail num", r_num, 16'hFFFF);
          chk_map("R4 map kept");
        end else begin
          chk("R5 block outcome", r_code, 2);
          chk_map("R5 map kept");
        end
      end
    end
  endtask

  initial begin : watchdog
    #900000;
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 resp_valid", int'(resp_valid), 0);
    chk_map("R1 reset");

    for (int n = 1; n <= 6; n++) begin
      issue(2'd0, n, 1'b0, 1'b1, 0);
      chk("R9 latency", lat, n);
      chk("R8 busy seen", int'(busy_seen), 1);
      chk("R3 start on empty", r_num, BASEV);
      model_set(0, n, 1'b1);
      chk_map("R2 level type");
      issue(2'd2, n, 1'b0, 1'b0, 0);
      chk("R7 release ok", r_code, 0);
      model_clr(0, n);
    end

    issue(2'd1, 1, 1'b0, 1'b1, 5);
    chk("R6 hint free", r_code, 0);
    model_set(5, 1, 1'b1);
    issue(2'd1, 1, 1'b0, 1'b0, 5);
    chk("R6 hint taken", r_code, 1);
    chk("R6 hint taken latency", lat, 1);
    chk_map("R6 map kept");
    issue(2'd2, 3, 1'b0, 1'b0, 4);
    chk("R7 partial release ok", r_code, 0);
    chk("R7 partial release warn", r_warn, 1);
    model_clr(4, 3);
    chk_map("R7 partial release");
    issue(2'd1, 1, 1'b0, 1'b0, 14);
    model_set(14, 1, 1'b0);
    issue(2'd2, 3, 1'b0, 1'b0, 14);
    chk("R5 release past end", r_code, 2);
    chk_map("R5 release past end map");
    issue(2'd3, 1, 1'b0, 1'b0, 0);
    chk("R5 reserved op", r_code, 2);
    issue(2'd2, 0, 1'b0, 1'b0, 3);
    chk("R5 release count 0", r_code, 2);
    issue(2'd2, 1, 1'b0, 1'b0, 14);
    model_clr(14, 1);

    // R8: a request presented during a scan is dropped
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_count = CW'(8); req_align = 1'b0;
    req_lvl = 1'b0; req_slot = '0;
    @(negedge clk);
    req_op = 2'd1; req_slot = SW'(15); req_lvl = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 scan answered ok", int'(resp_ok), 1);
    model_set(0, 8, 1'b0);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        if (resp_valid) extra++;
      end
      chk("R8 no second answer", extra, 0);
    end
    chk_map("R8 slot 15 untouched");
    issue(2'd2, 8, 1'b0, 1'b0, 0);
    model_clr(0, 8);

    sweep(16'h0000);
    sweep(16'h0101);
    sweep(16'h8421);
    sweep(16'h00F0);
    sweep(16'h0F0F);
    sweep(16'hFFFE);
    sweep(16'hFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule